// File: doc/BRIEF.md
# Multiplexed Key Matrix Reader

This block is a single byte-wide register through which a host scans eight buttons wired as two groups of four. The host writes a two-bit group select. Reading the register then returns the chosen group as four active-low lines, so a pressed button reads as 0. The select bits are active-low. Clearing one bit enables one group. Clearing both enables both groups, and their lines are wire-ORed. With neither group enabled, the low nibble carries a fixed indication that depends on a multi-controller mode flag.

The pressed-key vector is active-high: bit n set means button n is down. The read path is combinational from the stored select and the live key inputs. A one-cycle keypad interrupt pulse is produced one clock after the host strobes a check, provided that at least one line of the evaluated read value is active.

Top module: `keymx_reader`

## Requirements
- R1: After reset the select is 2'b11. With no keys pressed and the multi-controller flag low, rd_data reads 8'hFF.
- R2: A write loads wr_data[5:4] into the select. From the next clock on, rd_data[5:4] equals those bits and rd_data[7:6] reads 2'b11.
- R3: With select 2'b10, rd_data[3:0] equals the inverse of keys[3:0] (the lower group).
- R4: With select 2'b01, rd_data[3:0] equals the inverse of keys[7:4] (the upper group).
- R5: With select 2'b00, rd_data[3:0] equals the inverse of keys[3:0] | keys[7:4].
- R6: With select 2'b11, rd_data[3:0] reads 4'h0 when multi_mode is high and 4'hF when it is low.
- R7: When irq_check is high in a cycle where rd_data[3:0] is not 4'hF, irq_pulse is high for exactly the following cycle.
- R8: irq_pulse stays low in the cycle after a cycle where irq_check is low or rd_data[3:0] is 4'hF.
- R9: wr_data bits other than 5:4 have no effect on rd_data. Without a write, the select holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are used |
| keys | input | 8 | Pressed-key vector, 1 = pressed; 3:0 lower group, 7:4 upper group |
| multi_mode | input | 1 | Multi-controller indication enable |
| irq_check | input | 1 | Strobe to evaluate the keypad interrupt condition |
| rd_data | output | 8 | Register read value |
| irq_pulse | output | 1 | One-cycle keypad interrupt request |

## Verification
The assertions assume that keys and multi_mode are known and held across each sampling point. They compare rd_data against keys in the same cycle, with no allowance for glitches or metastability on the key lines. The bench meets this by changing every input only on the falling clock edge and holding it for a full period. Because random writes are mixed with checks and key patterns, all four select values occur with pressed and released keys. Directed steps add the all-pressed case, the none-pressed case, and a toggle of the multi-controller flag with no group selected.

// File: rtl/keymx_pkg.sv
package keymx_pkg;
    localparam int GROUP_W   = 4;
    localparam int SEL_W     = 2;
    localparam int NUM_KEYS  = GROUP_W * SEL_W;
    localparam int DATA_W    = 8;
    localparam int SEL_LSB   = 4;

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [GROUP_W-1:0] nib_t;

    localparam sel_t SEL_RESET = '1;

    typedef struct packed {
        sel_t sel;
        logic irq;
    } keymx_state_t;
endpackage

// File: rtl/keymx_group_mux.sv
module keymx_group_mux
    import keymx_pkg::*;
(
    input  sel_t                sel,
    input  logic [NUM_KEYS-1:0] keys,
    input  logic                multi_mode,
    output nib_t                active_nib
);
    nib_t [SEL_W-1:0] grp_term;
    nib_t             merged;

    genvar g;
    generate
        for (g = 0; g < SEL_W; g++) begin : g_grp
            assign grp_term[g] = sel[g] ? '0 : keys[g*GROUP_W +: GROUP_W];
        end
    endgenerate

    always_comb begin
        merged = '0;
        for (int i = 0; i < SEL_W; i++) begin
            merged = merged | grp_term[i];
        end
        if (&sel) begin
            active_nib = multi_mode ? '1 : '0;
        end else begin
            active_nib = merged;
        end
    end
endmodule

// File: rtl/keymx_ctrl.sv
module keymx_ctrl
    import keymx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_check,
    input  nib_t              active_nib,
    output sel_t              sel,
    output logic              irq
);
    keymx_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.irq = irq_check && (active_nib != '0);
        if (wr_en) begin
            state_d.sel = wr_data[SEL_LSB +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sel: SEL_RESET, irq: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign sel = state_q.sel;
    assign irq = state_q.irq;
endmodule

// File: rtl/keymx_reader.sv
module keymx_reader
    import keymx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        keys,
    input  logic              multi_mode,
    input  logic              irq_check,
    output logic [7:0]        rd_data,
    output logic              irq_pulse
);
    localparam int PAD_W = DATA_W - SEL_LSB - SEL_W;

    sel_t sel_q;
    nib_t active_nib;

    keymx_group_mux u_mux (
        .sel        (sel_q),
        .keys       (keys),
        .multi_mode (multi_mode),
        .active_nib (active_nib)
    );

    keymx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .irq_check  (irq_check),
        .active_nib (active_nib),
        .sel        (sel_q),
        .irq        (irq_pulse)
    );

    assign rd_data = {{PAD_W{1'b1}}, sel_q, ~active_nib};
endmodule

// File: rtl/keymx_checker.sv
module keymx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] keys,
    input logic       multi_mode,
    input logic       irq_check,
    input logic [7:0] rd_data,
    input logic       irq_pulse
);
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[5:4] == $past(wr_data[5:4])); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[5:4])); // R9
    AST_LOW_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == 2'b10 |-> rd_data[3:0] == ~keys[3:0]); // R3
    AST_HIGH_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == 2'b01 |-> rd_data[3:0] == ~keys[7:4]); // R4
    AST_BOTH_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == 2'b00 |-> rd_data[3:0] == ~(keys[3:0] | keys[7:4])); // R5
    AST_NO_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == 2'b11 |-> rd_data[3:0] == (multi_mode ? 4'h0 : 4'hF)); // R6
    AST_IRQ_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_check && rd_data[3:0] != 4'hF) |=> irq_pulse); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_check || rd_data[3:0] == 4'hF) |=> !irq_pulse); // R8
endmodule

bind keymx_reader keymx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .keys       (keys),
    .multi_mode (multi_mode),
    .irq_check  (irq_check),
    .rd_data    (rd_data),
    .irq_pulse  (irq_pulse)
);

// File: tb/keymx_reader_bench.sv
module keymx_reader_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] keys = 8'h00;
    logic       multi_mode = 1'b0;
    logic       irq_check = 1'b0;
    logic [7:0] rd_data;
    logic       irq_pulse;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [1:0] sel_m = 2'b11;
    logic       irq_m = 1'b0;

    always #5 clk = ~clk;

    keymx_reader u_keymx_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .keys       (keys),
        .multi_mode (multi_mode),
        .irq_check  (irq_check),
        .rd_data    (rd_data),
        .irq_pulse  (irq_pulse)
    );

    function automatic logic [3:0] exp_nib(logic [1:0] s, logic [7:0] k, logic m);
        logic [3:0] n;
        n = 4'h0;
        if (!s[0]) n = n | k[3:0];
        if (!s[1]) n = n | k[7:4];
        if (s == 2'b11) n = m ? 4'hF : 4'h0;
        return n;
    endfunction

    function automatic string nib_req(logic [1:0] s);
        case (s)
            2'b10:   return "R3";
            2'b01:   return "R4";
            2'b00:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic we, logic [7:0] wd, logic [7:0] k, logic m, logic chk);
        @(negedge clk);
        check(irq_m ? "R7 irq pulse" : "R8 no irq", {31'd0, irq_pulse}, {31'd0, irq_m});
        wr_en = we; wr_data = wd; keys = k; multi_mode = m; irq_check = chk;
        #1;
        check("R2 R9 upper bits", {28'd0, rd_data[7:4]}, {28'd0, 2'b11, sel_m});
        check(nib_req(sel_m), {28'd0, rd_data[3:0]}, {28'd0, ~exp_nib(sel_m, k, m)});
        irq_m = chk && (exp_nib(sel_m, k, m) != 4'h0);
        if (we) sel_m = wd[5:4];
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #22;
        check("R1 reset read", {24'd0, rd_data}, 32'hFF);
        check("R1 reset irq", {31'd0, irq_pulse}, 32'd0);
        rst_n = 1'b1;
        // directed: each select, all pressed / none pressed, multi toggle
        step(1'b1, 8'hEF, 8'h00, 1'b0, 1'b0); // R9 other bits set
        step(1'b0, 8'h00, 8'h5A, 1'b0, 1'b1); // R3
        step(1'b0, 8'h00, 8'hF0, 1'b0, 1'b1); // R8 lower group idle
        step(1'b1, 8'h10, 8'hFF, 1'b0, 1'b1); // R7
        step(1'b0, 8'h00, 8'h3C, 1'b0, 1'b0); // R4
        step(1'b1, 8'hCF, 8'h81, 1'b0, 1'b1); // R5
        step(1'b0, 8'h00, 8'h18, 1'b1, 1'b0);
        step(1'b1, 8'h30, 8'hFF, 1'b0, 1'b1); // R6 flag low
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b1); // R6 flag high
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) == 0, 8'($urandom), 8'($urandom), 1'($urandom),
                 1'($urandom));
        end
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule